// File: doc/BRIEF.md
# Free-Running Slow-Reference Tick Counter

This block is a read-only timer peripheral. It counts the rising edges of a slow 32.768 kHz reference after bringing that reference into the bus clock domain. Software reads the count, and a constant identification value, through a small register window. The count starts at zero when reset is released and then runs freely. It wraps around silently when it overflows.

The window accepts full-word (4-byte) and half-word (2-byte) reads. A half-word read of the lower half of a register returns the low 16 bits. In the same cycle it latches the upper 16 bits of that same sample into a holding register. A later half-word read of the upper half returns the latched bits, so a 32-bit value read in two halves never tears. Writes, byte reads, misaligned reads, illegal sizes and reads of unmapped offsets are all refused with a one-cycle error pulse.

Top module: `tick32_top`

## Requirements
- R1: Each rising edge of `ref_tick_i` advances the count by exactly one. The reference passes through a two-flop synchroniser and an edge detector, so the count reflects an edge at most four bus clocks after it.
- R2: Once reset is released, the count reads as zero until the first reference edge.
- R3: A count at its all-ones value wraps to zero on the next edge, and no error or other flag is raised.
- R4: A word read (size code 4) at byte offset 0x00 returns the identification value 0x00000021 with no error.
- R5: A word read at byte offset 0x10 returns the current count, zero-extended to 32 bits, with no error.
- R6: A half-word read (size code 2) at an address with bits [1:0] = 00 returns the low 16 bits of the word at that offset, in rdata[15:0] with rdata[31:16] zero. It also loads the high 16 bits of the same word into the holding register.
- R7: A half-word read at an address with bits [1:0] = 10 returns the holding register, not a fresh sample, with no error. The remaining address bits do not matter.
- R8: A write of any size raises the error pulse and returns zero data. It leaves both the count and the holding register unchanged.
- R9: The following reads raise the error pulse, return zero and leave the holding register unchanged: size code 1 (byte), any size code other than 1, 2 or 4, a word read with address bits [1:0] not 00, and a half-word read with address bit 0 set.
- R10: An otherwise legal read of an offset other than 0x00 or 0x10 returns zero and raises the error pulse. A half-word low read of such an offset loads zero into the holding register.
- R11: The response is registered. Data and error appear in the cycle after the strobe and last one cycle. In any cycle that follows no strobe, data is zero and error is low. A strobe with both read and write set is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ref_tick_i | input | 1 | Slow reference, asynchronous to clk |
| bus_rd_i | input | 1 | One-cycle read strobe |
| bus_wr_i | input | 1 | One-cycle write strobe |
| bus_addr_i | input | ADDR_W | Byte address within the window |
| bus_size_i | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| bus_err_o | output | 1 | One-cycle error pulse for refused accesses |

## Verification
The counter is driven by slow, well-separated reference pulses and by long bursts that toggle the reference every bus clock. Slow pulses show that each edge counts exactly once. Bursts show that back-to-back edges are not lost, and they carry the count across 0xFFFF into the upper half. A second instance with an 8-bit count is driven by the same reference, so its wrap to zero is seen through the same reads. Every word-aligned offset of the window is read with word size, which separates the identification value, the live count and unmapped offsets. The half-word sequence is run around the 0xFFFF to 0x10000 transition, where returning the held upper half instead of a fresh one changes the value read. Writes, byte reads, illegal sizes and misaligned reads are placed between the two halves to show they leave the held value alone.

// File: rtl/t32_pkg.sv
package t32_pkg;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned HALF_W = 16;

  localparam logic [2:0] SZ_BYTE = 3'd1;
  localparam logic [2:0] SZ_HALF = 3'd2;
  localparam logic [2:0] SZ_WORD = 3'd4;

  localparam logic [31:0] OFF_ID  = 32'h0000_0000;
  localparam logic [31:0] OFF_CNT = 32'h0000_0010;

  typedef struct packed {
    logic              hit;
    logic [BUS_W-1:0]  val;
  } word_rsp_t;

  // Decode one word-aligned byte offset into its register content.
  function automatic word_rsp_t word_lookup(input logic [31:0] word_addr,
                                            input logic [31:0] count_val,
                                            input logic [31:0] id_val);
    word_rsp_t r;
    r.hit = 1'b0;
    r.val = '0;
    if (word_addr == OFF_ID) begin
      r.hit = 1'b1;
      r.val = id_val;
    end else if (word_addr == OFF_CNT) begin
      r.hit = 1'b1;
      r.val = count_val;
    end
    return r;
  endfunction

  // Zero-extend a narrow half into the bus word.
  function automatic logic [BUS_W-1:0] half_to_bus(input logic [HALF_W-1:0] h);
    return {{(BUS_W-HALF_W){1'b0}}, h};
  endfunction

endpackage

// File: rtl/t32_ref_sync.sv
module t32_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= ref_async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/t32_ticker.sv
module t32_ticker #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o
);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      count_q <= '0;
    else if (step_i) count_q <= next_count(count_q);
  end

  assign count_o = count_q;

endmodule

// File: rtl/t32_regwin.sv
module t32_regwin
  import t32_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [31:0] ID_VAL = 32'h0000_0021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [BUS_W-1:0]  count_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              err_o,
  output logic [HALF_W-1:0] hold_o
);

  logic [31:0]       addr_full;
  word_rsp_t         lk;
  logic [BUS_W-1:0]  data_d, data_q;
  logic              err_d, err_q;
  logic [HALF_W-1:0] hold_d, hold_q;

  assign addr_full = 32'(addr_i);
  assign lk        = word_lookup({addr_full[31:2], 2'b00}, count_i, ID_VAL);

  always_comb begin
    data_d = '0;
    err_d  = 1'b0;
    hold_d = hold_q;
    if (wr_i) begin
      err_d = 1'b1;
    end else if (rd_i) begin
      unique case (size_i)
        SZ_WORD: begin
          if (addr_i[1:0] != 2'b00) begin
            err_d = 1'b1;
          end else begin
            data_d = lk.val;
            err_d  = !lk.hit;
          end
        end
        SZ_HALF: begin
          if (addr_i[0]) begin
            err_d = 1'b1;
          end else if (addr_i[1]) begin
            data_d = half_to_bus(hold_q);
          end else begin
            data_d = half_to_bus(lk.val[HALF_W-1:0]);
            hold_d = lk.val[BUS_W-1:HALF_W];
            err_d  = !lk.hit;
          end
        end
        default: err_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      err_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      data_q <= data_d;
      err_q  <= err_d;
      hold_q <= hold_d;
    end
  end

  assign rdata_o = data_q;
  assign err_o   = err_q;
  assign hold_o  = hold_q;

endmodule

// File: rtl/tick32_top.sv
module tick32_top
  import t32_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] ID_VAL      = 32'h0000_0021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [2:0]        bus_size_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_err_o
);

  logic              tick_w;
  logic [CNT_W-1:0]  count_w;
  logic [BUS_W-1:0]  count_bus_w;
  logic [HALF_W-1:0] hold_w;

  t32_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_async_i (ref_tick_i),
    .rise_o      (tick_w)
  );

  t32_ticker #(.CNT_W(CNT_W)) u_ticker (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (tick_w),
    .count_o (count_w)
  );

  assign count_bus_w = BUS_W'(count_w);

  t32_regwin #(.ADDR_W(ADDR_W), .ID_VAL(ID_VAL)) u_regwin (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_i    (bus_rd_i),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .size_i  (bus_size_i),
    .count_i (count_bus_w),
    .rdata_o (bus_rdata_o),
    .err_o   (bus_err_o),
    .hold_o  (hold_w)
  );

endmodule

// File: rtl/tick32_checker.sv
module tick32_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd,
  input logic             wr,
  input logic [1:0]       addr_lo,
  input logic [2:0]       size,
  input logic [31:0]      rdata,
  input logic             err,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic [15:0]      hold
);

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == CNT_W'($past(count) + 1'b1));

  assert_count_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_wrap_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&count) && !rd && !wr) |=> (count == '0 && !err));

  assert_half_hi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && size == 3'd2 && addr_lo == 2'b10) |=>
      (rdata == {16'h0000, $past(hold)} && !err));

  assert_write_keeps_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ($stable(hold) && err && rdata == 32'h0));

  assert_err_data_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rdata == 32'h0);

  assert_quiet_after_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !wr) |=> (!err && rdata == 32'h0));

endmodule

bind tick32_top tick32_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd      (bus_rd_i),
  .wr      (bus_wr_i),
  .addr_lo (bus_addr_i[1:0]),
  .size    (bus_size_i),
  .rdata   (bus_rdata_o),
  .err     (bus_err_o),
  .tick    (tick_w),
  .count   (count_w),
  .hold    (hold_w)
);

// File: tb/tick32_top_tb_top.sv
`timescale 1ns/1ps
module tick32_top_tb_top;

  localparam int unsigned AW      = 8;
  localparam int unsigned SMALL_W = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_tick = 1'b0;
  logic          rd = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [2:0]    size = 3'd4;
  logic [31:0]   rdata, rdata_s;
  logic          err, err_s;

  int unsigned total = 0;
  int unsigned bad   = 0;
  longint unsigned edges = 0;
  bit finished = 1'b0;

  logic [31:0] got_d, got_ds;
  logic        got_e, got_es;

  always #10 clk = ~clk;

  tick32_top #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_addr_i(addr), .bus_size_i(size),
    .bus_rdata_o(rdata), .bus_err_o(err)
  );

  tick32_top #(.ADDR_W(AW), .CNT_W(SMALL_W)) dut_w (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_addr_i(addr), .bus_size_i(size),
    .bus_rdata_o(rdata_s), .bus_err_o(err_s)
  );

  function automatic logic [31:0] exp_count32();
    return edges[31:0];
  endfunction

  function automatic logic [31:0] exp_small();
    return 32'(edges % (64'd1 << SMALL_W));
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input bit r, input bit w, input logic [AW-1:0] a,
                        input logic [2:0] s);
    @(negedge clk);
    rd = r; wr = w; addr = a; size = s;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    got_d = rdata; got_e = err; got_ds = rdata_s; got_es = err_s;
  endtask

  task automatic slow_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ref_tick = 1'b1;
      repeat (3) @(negedge clk);
      ref_tick = 1'b0;
      repeat (3) @(negedge clk);
      edges++;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic fast_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ref_tick = 1'b1;
      @(negedge clk) ref_tick = 1'b0;
    end
    edges += longint'(n);
    repeat (5) @(negedge clk);
  endtask

  task automatic read_count(input string tag);
    access(1'b1, 1'b0, 8'h10, 3'd4);
    check(got_d == exp_count32() && !got_e, tag, got_d, exp_count32());
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_v;
    bit          exp_e;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdata == 32'h0 && !err, "R11 reset outputs", rdata, 32'h0);

    // R2: zero after reset
    read_count("R2 count after reset");
    // R11: one-cycle response
    @(negedge clk);
    check(rdata == 32'h0 && !err, "R11 idle after read", rdata, 32'h0);

    // R4 id, R6/R7 halves of the id
    access(1'b1, 1'b0, 8'h00, 3'd4);
    check(got_d == 32'h21 && !got_e, "R4 id word", got_d, 32'h21);
    access(1'b1, 1'b0, 8'h00, 3'd2);
    check(got_d == 32'h21 && !got_e, "R6 id low half", got_d, 32'h21);
    access(1'b1, 1'b0, 8'h02, 3'd2);
    check(got_d == 32'h0 && !got_e, "R7 id high half", got_d, 32'h0);

    // R1 counting, slow and fast
    slow_edges(5);
    read_count("R1 slow edges");
    fast_edges(37);
    read_count("R1 fast edges");

    // R5/R4/R10 word sweep of all aligned offsets
    for (int off = 0; off < 256; off += 4) begin
      exp_v = (off == 0) ? 32'h21 : (off == 16) ? exp_count32() : 32'h0;
      exp_e = !(off == 0 || off == 16);
      access(1'b1, 1'b0, AW'(off), 3'd4);
      check(got_d == exp_v && got_e == exp_e,
            (off == 0) ? "R4 sweep" : (off == 16) ? "R5 sweep" : "R10 sweep",
            {got_d[30:0], got_e}, {exp_v[30:0], exp_e});
    end

    // R9 bad widths and misaligned
    access(1'b1, 1'b0, 8'h10, 3'd1);
    check(got_d == 32'h0 && got_e, "R9 byte read", {got_d[30:0], got_e}, 32'h1);
    for (int s = 0; s < 8; s++) begin
      if (s == 2 || s == 4) continue;
      access(1'b1, 1'b0, 8'h10, 3'(s));
      check(got_d == 32'h0 && got_e, "R9 illegal size", {got_d[30:0], got_e}, 32'h1);
    end
    access(1'b1, 1'b0, 8'h12, 3'd4);
    check(got_d == 32'h0 && got_e, "R9 misaligned word", {got_d[30:0], got_e}, 32'h1);
    access(1'b1, 1'b0, 8'h11, 3'd2);
    check(got_d == 32'h0 && got_e, "R9 misaligned half", {got_d[30:0], got_e}, 32'h1);

    // R8 writes refused
    for (int s = 1; s <= 4; s = s * 2) begin
      access(1'b0, 1'b1, 8'h10, 3'(s));
      check(got_d == 32'h0 && got_e, "R8 write err", {got_d[30:0], got_e}, 32'h1);
    end
    access(1'b1, 1'b1, 8'h00, 3'd4);
    check(got_d == 32'h0 && got_e, "R11 rd+wr as write", {got_d[30:0], got_e}, 32'h1);
    read_count("R8 count unchanged by writes");

    // R3 wrap on the narrow instance
    fast_edges(int'(511 - edges));
    access(1'b1, 1'b0, 8'h10, 3'd4);
    check(got_ds == exp_small() && got_ds == 32'hFF, "R3 narrow at max", got_ds, 32'hFF);
    fast_edges(1);
    access(1'b1, 1'b0, 8'h10, 3'd4);
    check(got_ds == 32'h0 && !got_es, "R3 narrow wrapped", got_ds, 32'h0);
    fast_edges(44);
    access(1'b1, 1'b0, 8'h10, 3'd4);
    check(got_ds == exp_small() && !got_es, "R3 narrow after wrap", got_ds, exp_small());

    // R6/R7 tear-free halves across 0xFFFF -> 0x10000
    fast_edges(int'(32'hFFFF - edges));
    read_count("R1 long run");
    access(1'b1, 1'b0, 8'h10, 3'd2);
    check(got_d == 32'hFFFF && !got_e, "R6 low half before carry", got_d, 32'hFFFF);
    fast_edges(1);
    access(1'b1, 1'b0, 8'h12, 3'd2);
    check(got_d == 32'h0 && !got_e, "R7 held high not fresh", got_d, 32'h0);
    read_count("R5 after carry");
    access(1'b1, 1'b0, 8'h10, 3'd2);
    check(got_d == 32'h0 && !got_e, "R6 low half after carry", got_d, 32'h0);
    access(1'b1, 1'b0, 8'h12, 3'd2);
    check(got_d == 32'h1 && !got_e, "R6 high half latched", got_d, 32'h1);
    access(1'b1, 1'b0, 8'hE6, 3'd2);
    check(got_d == 32'h1 && !got_e, "R7 any address", got_d, 32'h1);
    access(1'b1, 1'b0, 8'h10, 3'd1);
    access(1'b1, 1'b0, 8'h12, 3'd2);
    check(got_d == 32'h1, "R9 byte read keeps hold", got_d, 32'h1);
    access(1'b0, 1'b1, 8'h10, 3'd2);
    access(1'b1, 1'b0, 8'h12, 3'd2);
    check(got_d == 32'h1, "R8 write keeps hold", got_d, 32'h1);
    access(1'b1, 1'b0, 8'h20, 3'd2);
    check(got_d == 32'h0 && got_e, "R10 bad half low", {got_d[30:0], got_e}, 32'h1);
    access(1'b1, 1'b0, 8'h12, 3'd2);
    check(got_d == 32'h0 && !got_e, "R10 hold cleared", got_d, 32'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule